// File: doc/BRIEF.md
# Two-Phase Dithered PWM Generator

This block generates a pulse-width-modulated output from an 8-bit duty word. It does not compare one 256-step count against the whole word. Each full PWM period is built from two half-periods of 128 timebase ticks, numbered 0 and 1, which always follow each other in that order. In both half-periods the output is high for a number of ticks set by the upper seven bits of the duty word. The least significant bit adds one more high tick to half-period 0 only. The output ripple therefore sits at twice the full-period rate, and the odd step of resolution is spread over the pair of halves.

The counter moves forward only on a single-cycle tick strobe that comes from an external prescaler. A duty word written at any time is held in a shadow register. It is copied into the working register only when one full period ends, so a period never mixes two duty values. Two control bits sit after the waveform. The gate bit works like a port data latch: when it is 0 the output is forced low. The direction bit selects output mode (0) or input mode (1). In input mode the pin driver is released and the PWM level is forced low.

The sequencer has two named states. `SUB_ZERO` is half-period 0, with the dither bit applied. `SUB_ONE` is half-period 1, with no dither. On a tick at position 127, transition `HALF_WRAP` goes from `SUB_ZERO` to `SUB_ONE`, and transition `PERIOD_WRAP` goes from `SUB_ONE` back to `SUB_ZERO`. `PERIOD_WRAP` also copies the shadow duty into the working register. Reset forces `SUB_ZERO` at position 0.

Top module: `dpwm_gen`

## Requirements
- R1: The duty word is 8 bits wide. Bits [7:1] are the base high count B (0..127), and bit [0] is the dither bit D.
- R2: Each half-period lasts 128 ticks, with positions 0..127. A full period lasts 256 ticks and always runs half-period 0 and then half-period 1.
- R3: In half-period 0 the output is high for exactly B+D ticks, starting at position 0 and running without a gap. It is low for the rest of that half-period.
- R4: In half-period 1 the output is high for exactly B ticks, starting at position 0 and running without a gap.
- R5: A duty word of 0 keeps the output low for the whole period. A duty word of 255 gives 128 high ticks in half-period 0 and 127 high ticks in half-period 1. No half-period is ever high for more than 128 ticks.
- R6: A duty word written during a period does not change that period. It takes effect from position 0 of the next full period.
- R7: While the gate bit is 0, `pwm_out` is low.
- R8: While the direction bit is 1, `pwm_oe` is 0 and `pwm_out` is low. While the direction bit is 0, `pwm_oe` is 1.
- R9: Position and half-period change only on clock edges where `tick` is 1. Clock edges without `tick` leave the output waveform where it is.
- R10: A synchronous active-high reset puts the sequencer at position 0 of half-period 0. It clears both the shadow and the working duty to 0, clears the gate bit to 0, and sets the direction bit to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase strobe; one tick advances the position by one |
| duty_we | input | 1 | Write strobe for the shadow duty register |
| duty_wdata | input | 8 | Duty word: bits [7:1] base count, bit [0] dither |
| gate_we | input | 1 | Write strobe for the gate bit |
| gate_wdata | input | 1 | Gate bit value (1 = waveform passes) |
| dir_we | input | 1 | Write strobe for the direction bit |
| dir_wdata | input | 1 | Direction value (0 = output, 1 = input) |
| pwm_out | output | 1 | Gated PWM level |
| pwm_oe | output | 1 | Pin driver enable (high in output mode) |

## Verification
The hardest thing to reach from the ports is a duty write that lands in the middle of a period. A broken shadow path shows up only as one distorted period, and that period must be lined up exactly with the period boundary. The bench follows the position itself by counting ticks from reset. It sweeps all 256 duty words so that each new word is written at position 10 of the period that is still measuring the previous word. The high counts of every period therefore check the hold-until-boundary rule as well as the base-plus-dither split. A pause in `tick` is placed inside a high stretch. The bench then looks for the falling edge at the exact tick position where a paused counter must put it.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

    // Half-period state of the sequencer
    typedef enum logic {
        SUB_ZERO = 1'b0,
        SUB_ONE  = 1'b1
    } sub_e;

endpackage

// File: rtl/dpwm_duty.sv
module dpwm_duty #(
    parameter int DUTY_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [DUTY_W-1:0] wdata,
    input  logic              load,
    output logic [DUTY_W-1:0] active
);

    logic [DUTY_W-1:0] shadow_q;
    logic [DUTY_W-1:0] active_q;

    // Writes go to the shadow copy at any time; the working copy follows
    // only at the end of a full period.
    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            active_q <= '0;
        end else begin
            if (wr) begin
                shadow_q <= wdata;
            end
            if (load) begin
                active_q <= shadow_q;
            end
        end
    end

    assign active = active_q;

endmodule

// File: rtl/dpwm_seq.sv
module dpwm_seq
    import dpwm_pkg::*;
#(
    parameter int POS_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [POS_W:0]   duty,
    output logic [POS_W-1:0] pos,
    output logic             sub_one,
    output logic             raw,
    output logic             period_end
);

    localparam logic [POS_W-1:0] POS_LAST = '1;

    sub_e             state_q;
    sub_e             state_nx;
    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] pos_nx;
    logic             half_end;
    logic [POS_W:0]   thr;

    assign half_end = tick && (pos_q == POS_LAST);

    // Next-state logic: HALF_WRAP and PERIOD_WRAP
    always_comb begin
        state_nx = state_q;
        pos_nx   = pos_q;
        if (tick) begin
            pos_nx = pos_q + 1'b1;
        end
        unique case (state_q)
            SUB_ZERO: if (half_end) state_nx = SUB_ONE;
            SUB_ONE:  if (half_end) state_nx = SUB_ZERO;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SUB_ZERO;
            pos_q   <= '0;
        end else begin
            state_q <= state_nx;
            pos_q   <= pos_nx;
        end
    end

    // Outputs: threshold per half-period and the compare
    always_comb begin
        thr        = {1'b0, duty[POS_W:1]};
        period_end = 1'b0;
        unique case (state_q)
            SUB_ZERO: thr = thr + {{POS_W{1'b0}}, duty[0]};
            SUB_ONE:  period_end = half_end;
        endcase
        raw = ({1'b0, pos_q} < thr);
    end

    assign pos     = pos_q;
    assign sub_one = (state_q == SUB_ONE);

endmodule

// File: rtl/dpwm_gate.sv
module dpwm_gate (
    input  logic clk,
    input  logic rst,
    input  logic gate_we,
    input  logic gate_wdata,
    input  logic dir_we,
    input  logic dir_wdata,
    input  logic raw,
    output logic gate_q,
    output logic dir_q,
    output logic pwm_out,
    output logic pwm_oe
);

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= 1'b0;
            dir_q  <= 1'b1;
        end else begin
            if (gate_we) gate_q <= gate_wdata;
            if (dir_we)  dir_q  <= dir_wdata;
        end
    end

    assign pwm_out = raw & gate_q & ~dir_q;
    assign pwm_oe  = ~dir_q;

endmodule

// File: rtl/dpwm_gen.sv
module dpwm_gen #(
    parameter int DUTY_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              duty_we,
    input  logic [DUTY_W-1:0] duty_wdata,
    input  logic              gate_we,
    input  logic              gate_wdata,
    input  logic              dir_we,
    input  logic              dir_wdata,
    output logic              pwm_out,
    output logic              pwm_oe
);

    localparam int POS_W = DUTY_W - 1;

    logic [DUTY_W-1:0] act_duty;
    logic [POS_W-1:0]  pos_w;
    logic              sub_one;
    logic              raw;
    logic              period_end;
    logic              gate_q;
    logic              dir_q;

    dpwm_duty #(.DUTY_W(DUTY_W)) u_duty (
        .clk    (clk),
        .rst    (rst),
        .wr     (duty_we),
        .wdata  (duty_wdata),
        .load   (period_end),
        .active (act_duty)
    );

    dpwm_seq #(.POS_W(POS_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .duty       (act_duty),
        .pos        (pos_w),
        .sub_one    (sub_one),
        .raw        (raw),
        .period_end (period_end)
    );

    dpwm_gate u_gate (
        .clk        (clk),
        .rst        (rst),
        .gate_we    (gate_we),
        .gate_wdata (gate_wdata),
        .dir_we     (dir_we),
        .dir_wdata  (dir_wdata),
        .raw        (raw),
        .gate_q     (gate_q),
        .dir_q      (dir_q),
        .pwm_out    (pwm_out),
        .pwm_oe     (pwm_oe)
    );

endmodule

// File: rtl/dpwm_chk.sv
module dpwm_chk #(
    parameter int POS_W = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic [POS_W-1:0] pos,
    input logic             sub_one,
    input logic [POS_W:0]   act_duty,
    input logic             gate_q,
    input logic             dir_q,
    input logic             pwm_out,
    input logic             pwm_oe
);

    localparam logic [POS_W-1:0] LAST = '1;

    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    // R10: state one edge after reset
    always_ff @(posedge clk) begin
        if (rst_d) begin
            assert_reset_state_R10: assert (pos == '0 && !sub_one && !gate_q
                && dir_q && act_duty == '0)
                else $error("reset state wrong");
        end
    end

    assert_hold_no_tick_R9: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(pos) && $stable(sub_one)));

    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        (tick && pos != LAST) |=> (pos == POS_W'($past(pos) + 1'b1) && $stable(sub_one)));

    assert_half_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (tick && pos == LAST) |=> (pos == '0 && sub_one != $past(sub_one)));

    assert_load_at_period_R6: assert property (@(posedge clk) disable iff (rst || rst_d)
        !$stable(act_duty) |-> $past(tick && pos == LAST && sub_one));

    assert_gate_low_R7: assert property (@(posedge clk) disable iff (rst)
        !gate_q |-> !pwm_out);

    assert_input_mode_R8: assert property (@(posedge clk) disable iff (rst)
        dir_q |-> (!pwm_out && !pwm_oe));

    assert_no_regain_R3: assert property (@(posedge clk) disable iff (rst)
        (!pwm_out && tick && pos != LAST) |=> (!pwm_out || $rose(gate_q) || $fell(dir_q)));

endmodule

bind dpwm_gen dpwm_chk #(.POS_W(POS_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .pos      (pos_w),
    .sub_one  (sub_one),
    .act_duty (act_duty),
    .gate_q   (gate_q),
    .dir_q    (dir_q),
    .pwm_out  (pwm_out),
    .pwm_oe   (pwm_oe)
);

// File: tb/dpwm_gen_tb.sv
`timescale 1ns/1ps
module dpwm_gen_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b1;
    logic       duty_we = 1'b0;
    logic [7:0] duty_wdata = '0;
    logic       gate_we = 1'b0;
    logic       gate_wdata = 1'b0;
    logic       dir_we = 1'b0;
    logic       dir_wdata = 1'b0;
    logic       pwm_out;
    logic       pwm_oe;

    int  checks = 0;
    int  errors = 0;
    int  pos_b  = 0;
    bit  cur_dir = 1'b1;
    bit  done = 1'b0;

    // {duty, high count half 0, high count half 1}
    localparam int NVEC = 10;
    localparam logic [23:0] VEC [NVEC] = '{
        {8'd100, 8'd50,  8'd50},
        {8'd101, 8'd51,  8'd50},
        {8'd102, 8'd51,  8'd51},
        {8'd103, 8'd52,  8'd51},
        {8'd0,   8'd0,   8'd0},
        {8'd1,   8'd1,   8'd0},
        {8'd254, 8'd127, 8'd127},
        {8'd255, 8'd128, 8'd127},
        {8'd2,   8'd1,   8'd1},
        {8'd128, 8'd64,  8'd64}
    };

    dpwm_gen u_dut (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .duty_we    (duty_we),
        .duty_wdata (duty_wdata),
        .gate_we    (gate_we),
        .gate_wdata (gate_wdata),
        .dir_we     (dir_we),
        .dir_wdata  (dir_wdata),
        .pwm_out    (pwm_out),
        .pwm_oe     (pwm_oe)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        bit t = tick;
        bit r = rst;
        @(posedge clk);
        #1;
        if (r) pos_b = 0;
        else if (t) pos_b = (pos_b + 1) % 256;
    endtask

    // One full period starting at position 0: counts high ticks per half,
    // optional duty write at position 10, optional gate/dir write at 255.
    task automatic measure(input int e0, input int e1, input bit wr, input logic [7:0] wv,
                           input bit sg, input bit gv, input bit sd, input bit dv,
                           input string tag);
        int h0 = 0;
        int h1 = 0;
        int bad = 0;
        int oe_bad = 0;
        bit low_seen = 1'b0;
        bit exp_oe = !cur_dir;
        for (int p = 0; p < 256; p++) begin
            if (p == 128) low_seen = 1'b0;
            if (pwm_out === 1'b1) begin
                if (low_seen) bad++;
                if (p < 128) h0++; else h1++;
            end else begin
                low_seen = 1'b1;
            end
            if (pwm_oe !== exp_oe) oe_bad++;
            duty_we    = wr && (p == 10);
            duty_wdata = wv;
            gate_we    = sg && (p == 255);
            gate_wdata = gv;
            dir_we     = sd && (p == 255);
            dir_wdata  = dv;
            step();
        end
        duty_we = 1'b0;
        gate_we = 1'b0;
        dir_we  = 1'b0;
        if (sd) cur_dir = dv;
        check(h0 == e0, {tag, " R3 half0 high count"}, h0, e0);
        check(h1 == e1, {tag, " R4 half1 high count"}, h1, e1);
        check(bad == 0, {tag, " R2 contiguous high from half start"}, bad, 0);
        check(oe_bad == 0, {tag, " R8 pwm_oe level"}, oe_bad, 0);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int p0;
        int p1;
        int prev;
        repeat (3) step();
        // R10: reset state at the ports
        check(pwm_oe == 1'b0, "R10 reset pwm_oe", pwm_oe, 0);
        check(pwm_out == 1'b0, "R10 reset pwm_out", pwm_out, 0);
        rst = 1'b0;
        pos_b = 0;

        // First period: duty cleared by reset (R10), set gate=1/dir=0 at end
        measure(0, 0, 1'b0, 8'd0, 1'b1, 1'b1, 1'b1, 1'b0, "R10 duty after reset");

        // Full sweep: each write lands mid-period and applies next period (R1, R6)
        prev = 0;
        for (int v = 0; v < 256; v++) begin
            p0 = (prev >> 1) + (prev & 1);
            p1 = prev >> 1;
            measure(p0, p1, 1'b1, 8'(v), 1'b0, 1'b0, 1'b0, 1'b0, "R1 R6 sweep");
            prev = v;
        end

        // Vector table, includes R5 extremes
        p0 = 128;
        p1 = 127;
        for (int i = 0; i < NVEC; i++) begin
            measure(p0, p1, 1'b1, VEC[i][23:16], 1'b0, 1'b0, 1'b0, 1'b0, "R5 table");
            p0 = int'(VEC[i][15:8]);
            p1 = int'(VEC[i][7:0]);
        end

        // R7: gate off then back on; R8: input mode then output mode
        measure(64, 64, 1'b0, 8'd0, 1'b1, 1'b0, 1'b0, 1'b0, "R5 table last");
        measure(0, 0, 1'b0, 8'd0, 1'b1, 1'b1, 1'b1, 1'b1, "R7 gate off");
        measure(0, 0, 1'b0, 8'd0, 1'b0, 1'b0, 1'b1, 1'b0, "R8 input mode");
        measure(64, 64, 1'b0, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R8 output mode");

        // R9: pause ticks inside the high stretch, edge must move by the pause
        while (pos_b != 10) step();
        tick = 1'b0;
        p0 = 0;
        for (int k = 0; k < 30; k++) begin
            if (pwm_out !== 1'b1) p0++;
            step();
        end
        check(p0 == 0, "R9 output held while tick low", p0, 0);
        check(pos_b == 10, "R9 bench position held", pos_b, 10);
        tick = 1'b1;
        while (pos_b != 63) step();
        check(pwm_out == 1'b1, "R9 high at position 63", pwm_out, 1);
        step();
        check(pwm_out == 1'b0, "R9 low at position 64", pwm_out, 0);

        // R10: reset in mid-period
        while (pos_b != 100) step();
        rst = 1'b1;
        step();
        rst = 1'b0;
        cur_dir = 1'b1;
        check(pwm_oe == 1'b0, "R10 mid reset pwm_oe", pwm_oe, 0);
        check(pwm_out == 1'b0, "R10 mid reset pwm_out", pwm_out, 0);
        check(pos_b == 0, "R10 bench position", pos_b, 0);
        measure(0, 0, 1'b0, 8'd0, 1'b1, 1'b1, 1'b1, 1'b0, "R10 after mid reset");
        measure(0, 0, 1'b0, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R10 duty cleared");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule